// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that carries each instruction through fetch, decode, operand read, execution, data-memory access and result write-back inside a single clock period. It executes an integer subset of six operations: two register-register arithmetic operations (add and subtract, both wrapping), a logical OR with a 16-bit immediate, a word load, a word store and a branch taken on equal operands. The program counter, the register file and the data memory all change on the same rising edge.

The core holds its own instruction and data memories, each a word array whose depth is set by a parameter. A load port writes words into either memory while the core is held in reset, which is how a program and its initial data are placed before a run. A debug port returns the current program counter and the contents of any one register, so a checker outside the block can compare the architectural state against a model.

Internally the decoder first classifies the fetched word into one of seven kinds (KIND_NOP, KIND_ADDU, KIND_SUBU, KIND_ORI, KIND_LOAD, KIND_STORE, KIND_BRANCH) and then derives the datapath controls from that kind alone. The only sequential state besides the memories is the program counter, which moves from reset to address 0 and then each cycle either to the next word or to a branch target.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge the program counter becomes 0, and no register or data-memory word is written by the core in that cycle.
- R2: A word with bits [31:26]=0 and bits [5:0]=0x21 writes rs+rt modulo 2^32 into rd; with bits [5:0]=0x23 it writes rs-rt modulo 2^32 into rd. rs is bits [25:21], rt bits [20:16], rd bits [15:11].
- R3: Opcode 0x0D writes rs OR the zero-extended 16-bit immediate (bits [15:0]) into rt.
- R4: Opcode 0x23 loads into rt the data word at address rs + sign-extended immediate.
- R5: Opcode 0x2B stores rt to the data word at address rs + sign-extended immediate; the data memory is written by the core for no other opcode.
- R6: Opcode 0x04 compares rs with rt; when equal the next PC is PC+4 plus the sign-extended immediate shifted left by two, otherwise PC+4.
- R7: Every instruction other than a taken branch advances the PC by exactly 4.
- R8: Register 0 reads as zero at all times and a write to it has no effect.
- R9: Any other opcode, and opcode 0 with any other function field, changes no register and no memory word and only advances the PC by 4.
- R10: Both memories are word-addressed by address bits [MEM_AW+1:2]; the two low bits are ignored and higher bits wrap, and the PC stays word-aligned.
- R11: With `load_en` high at a rising edge, `load_data` is written to word `load_addr` of the data memory when `load_dmem` is 1, or of the instruction memory when it is 0.
- R12: `dbg_pc` shows the current PC and `dbg_reg_data` combinationally shows the register selected by `dbg_reg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; holds PC at 0 and blocks core writes |
| load_en | input | 1 | Write one word through the load port this cycle |
| load_dmem | input | 1 | Load target: 1 data memory, 0 instruction memory |
| load_addr | input | MEM_AW | Word index written by the load port |
| load_data | input | 32 | Word written by the load port |
| dbg_reg_sel | input | 5 | Register number shown on `dbg_reg_data` |
| dbg_pc | output | 32 | Current program counter |
| dbg_reg_data | output | 32 | Contents of the selected register |

## Verification
The bench runs a short program against an arithmetic model of the six operations and checks the PC after every cycle, then every register the program touched. It aims at the places a single-cycle core tends to slip: a subtract that must wrap below zero, an OR immediate with bit 15 set (sign extension there would fill the upper half with ones), a store and load at a negative offset that must wrap to the top memory word, a load whose address has nonzero low bits, and a write aimed at register 0. It also plants an unsupported function code and an unknown opcode whose destination fields point at live registers, so a decoder that falls through to a write corrupts a value the bench later reads, and it runs a not-taken branch, a forward taken branch past two writes and a branch back onto itself, which catch a target computed from PC instead of PC+4 or an unshifted offset.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN   = 32;
    localparam int REG_AW = 5;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADD    = 6'h21;
    localparam logic [5:0] FN_SUB    = 6'h23;

    typedef enum logic [2:0] {
        KIND_NOP,
        KIND_ADDU,
        KIND_SUBU,
        KIND_ORI,
        KIND_LOAD,
        KIND_STORE,
        KIND_BRANCH
    } inst_kind_e;

    typedef enum logic [1:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_OR
    } alu_op_e;

    typedef struct packed {
        logic    reg_wr;
        logic    dst_rd;
        logic    src_imm;
        logic    ext_sign;
        logic    mem_wr;
        logic    mem_to_reg;
        logic    branch;
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/sc_decoder.sv
module sc_decoder
    import sc_pkg::*;
(
    input  logic [5:0]  opcode,
    input  logic [5:0]  funct,
    output inst_kind_e  kind,
    output ctrl_t       ctrl
);

    // classify the instruction word
    always_comb begin
        kind = KIND_NOP;
        unique case (opcode)
            OPC_RTYPE: begin
                if (funct == FN_ADD)      kind = KIND_ADDU;
                else if (funct == FN_SUB) kind = KIND_SUBU;
                else                      kind = KIND_NOP;
            end
            OPC_ORI:   kind = KIND_ORI;
            OPC_LOAD:  kind = KIND_LOAD;
            OPC_STORE: kind = KIND_STORE;
            OPC_BEQ:   kind = KIND_BRANCH;
            default:   kind = KIND_NOP;
        endcase
    end

    // datapath controls follow from the kind alone
    always_comb begin
        ctrl = '0;
        ctrl.alu_op = ALU_ADD;
        unique case (kind)
            KIND_ADDU: begin
                ctrl.reg_wr = 1'b1;
                ctrl.dst_rd = 1'b1;
            end
            KIND_SUBU: begin
                ctrl.reg_wr = 1'b1;
                ctrl.dst_rd = 1'b1;
                ctrl.alu_op = ALU_SUB;
            end
            KIND_ORI: begin
                ctrl.reg_wr  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.alu_op  = ALU_OR;
            end
            KIND_LOAD: begin
                ctrl.reg_wr     = 1'b1;
                ctrl.src_imm    = 1'b1;
                ctrl.ext_sign   = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            KIND_STORE: begin
                ctrl.src_imm  = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.mem_wr   = 1'b1;
            end
            KIND_BRANCH: begin
                ctrl.branch   = 1'b1;
                ctrl.ext_sign = 1'b1;
                ctrl.alu_op   = ALU_SUB;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);

    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra_a,
    output logic [W-1:0]  rd_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_b,
    input  logic [AW-1:0] ra_c,
    output logic [W-1:0]  rd_c
);

    localparam int NREG = 1 << AW;

    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && waddr != '0) regs[waddr] <= wdata;
    end

    assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];
    assign rd_c = (ra_c == '0) ? '0 : regs[ra_c];

endmodule

// File: rtl/sc_mem.sv
module sc_mem #(
    parameter int W  = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    assign rdata = words[raddr];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              load_dmem,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [31:0]       load_data,
    input  logic [4:0]        dbg_reg_sel,
    output logic [31:0]       dbg_pc,
    output logic [31:0]       dbg_reg_data
);

    localparam int WIDX_LO = 2;
    localparam int WIDX_HI = MEM_AW + 1;

    logic [XLEN-1:0]   pc_q, pc_next, pc_plus4, br_target;
    logic [XLEN-1:0]   instr;
    logic [5:0]        f_op, f_fn;
    logic [REG_AW-1:0] f_rs, f_rt, f_rd;
    logic [15:0]       f_imm;
    inst_kind_e        inst_kind;
    ctrl_t             ctrl;
    logic [XLEN-1:0]   bus_a, bus_b, ext_imm, alu_b, alu_y, dmem_rdata, wb_data;
    logic              alu_zero, br_taken;
    logic              core_rf_we, core_dmem_we;
    logic [REG_AW-1:0] wb_addr;
    logic              imem_we, dmem_we;
    logic [MEM_AW-1:0] dmem_waddr;
    logic [XLEN-1:0]   dmem_wdata;
    logic              unused_bits;

    // fetch
    sc_mem #(.W(XLEN), .AW(MEM_AW)) u_imem (
        .clk   (clk),
        .we    (imem_we),
        .waddr (load_addr),
        .wdata (load_data),
        .raddr (pc_q[WIDX_HI:WIDX_LO]),
        .rdata (instr)
    );

    assign f_op  = instr[31:26];
    assign f_rs  = instr[25:21];
    assign f_rt  = instr[20:16];
    assign f_rd  = instr[15:11];
    assign f_fn  = instr[5:0];
    assign f_imm = instr[15:0];

    // decode
    sc_decoder u_dec (
        .opcode (f_op),
        .funct  (f_fn),
        .kind   (inst_kind),
        .ctrl   (ctrl)
    );

    // operand read and write-back
    sc_regfile #(.W(XLEN), .AW(REG_AW)) u_rf (
        .clk   (clk),
        .we    (core_rf_we),
        .waddr (wb_addr),
        .wdata (wb_data),
        .ra_a  (f_rs),
        .rd_a  (bus_a),
        .ra_b  (f_rt),
        .rd_b  (bus_b),
        .ra_c  (dbg_reg_sel),
        .rd_c  (dbg_reg_data)
    );

    assign ext_imm = ctrl.ext_sign ? {{16{f_imm[15]}}, f_imm} : {16'h0000, f_imm};
    assign alu_b   = ctrl.src_imm ? ext_imm : bus_b;

    // execute
    sc_alu #(.W(XLEN)) u_alu (
        .a    (bus_a),
        .b    (alu_b),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory; the load port wins while it is active
    assign core_dmem_we = ctrl.mem_wr & ~rst;
    assign dmem_we      = (load_en & load_dmem) | core_dmem_we;
    assign imem_we      = load_en & ~load_dmem;
    assign dmem_waddr   = (load_en & load_dmem) ? load_addr : alu_y[WIDX_HI:WIDX_LO];
    assign dmem_wdata   = (load_en & load_dmem) ? load_data : bus_b;

    sc_mem #(.W(XLEN), .AW(MEM_AW)) u_dmem (
        .clk   (clk),
        .we    (dmem_we),
        .waddr (dmem_waddr),
        .wdata (dmem_wdata),
        .raddr (alu_y[WIDX_HI:WIDX_LO]),
        .rdata (dmem_rdata)
    );

    assign wb_data    = ctrl.mem_to_reg ? dmem_rdata : alu_y;
    assign wb_addr    = ctrl.dst_rd ? f_rd : f_rt;
    assign core_rf_we = ctrl.reg_wr & ~rst;

    // next address
    assign pc_plus4  = pc_q + 32'd4;
    assign br_target = pc_plus4 + {ext_imm[XLEN-3:0], 2'b00};
    assign br_taken  = ctrl.branch & alu_zero;
    assign pc_next   = br_taken ? br_target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign dbg_pc      = pc_q;
    assign unused_bits = ^{instr[10:6], inst_kind};

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [4:0]  ra_addr,
    input logic [31:0] ra_data,
    input logic        is_branch,
    input logic        dmem_we_core
);

    a_r1_pc_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> pc == 32'd0);

    a_r7_seq_pc: assert property (@(posedge clk) disable iff (rst)
        !is_branch |=> pc == $past(pc) + 32'd4);

    a_r8_zero_read: assert property (@(posedge clk) disable iff (rst)
        ra_addr == 5'd0 |-> ra_data == 32'd0);

    a_r10_pc_aligned: assert property (@(posedge clk) disable iff (rst)
        pc[1:0] == 2'b00);

    a_r5_store_only: assert property (@(posedge clk) disable iff (rst)
        dmem_we_core |-> instr[31:26] == 6'h2B);

endmodule

bind sc_core sc_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .pc           (pc_q),
    .instr        (instr),
    .ra_addr      (f_rs),
    .ra_data      (bus_a),
    .is_branch    (ctrl.branch),
    .dmem_we_core (core_dmem_we)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          load_en, load_dmem;
    logic [AW-1:0] load_addr;
    logic [31:0]   load_data;
    logic [4:0]    dbg_reg_sel;
    logic [31:0]   dbg_pc, dbg_reg_data;

    always #2.5 clk = ~clk;

    sc_core #(.MEM_AW(AW)) uut (
        .clk          (clk),
        .rst          (rst),
        .load_en      (load_en),
        .load_dmem    (load_dmem),
        .load_addr    (load_addr),
        .load_data    (load_data),
        .dbg_reg_sel  (dbg_reg_sel),
        .dbg_pc       (dbg_pc),
        .dbg_reg_data (dbg_reg_data)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [31:0] prog  [DEPTH];
    logic [31:0] ref_m [DEPTH];
    logic [31:0] ref_r [32];
    bit          ref_known [32];
    logic [31:0] ref_pc;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic ref_wr(input logic [4:0] idx, input logic [31:0] val);
        if (idx != 5'd0) begin
            ref_r[idx]     = val;
            ref_known[idx] = 1'b1;
        end
    endtask

    // arithmetic model of the six operations
    task automatic ref_step();
        logic [31:0] w, a, b, sx, zx, ad, nxt;
        w   = prog[ref_pc[AW+1:2]];
        a   = ref_r[w[25:21]];
        b   = ref_r[w[20:16]];
        sx  = {{16{w[15]}}, w[15:0]};
        zx  = {16'h0, w[15:0]};
        ad  = a + sx;
        nxt = ref_pc + 32'd4;
        case (w[31:26])
            6'h00: begin
                if (w[5:0] == 6'h21)      ref_wr(w[15:11], a + b);
                else if (w[5:0] == 6'h23) ref_wr(w[15:11], a - b);
            end
            6'h0D: ref_wr(w[20:16], a | zx);
            6'h23: ref_wr(w[20:16], ref_m[ad[AW+1:2]]);
            6'h2B: ref_m[ad[AW+1:2]] = b;
            6'h04: if (a == b) nxt = nxt + (sx << 2);
            default: ;
        endcase
        ref_pc = nxt;
    endtask

    function automatic string reg_tag(input int r);
        case (r)
            0:       return "R8 register zero";
            1, 2:    return "R3 ori zero-extend";
            3, 4:    return "R2 R9 add/sub wrap, ignored encodings";
            5:       return "R4 R5 store then load";
            6:       return "R10 R6 negative offset wrap, skipped writes";
            7:       return "R10 low address bits ignored";
            10:      return "R11 data word placed by load port";
            default: return "R2 register value";
        endcase
    endfunction

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst         = 1'b1;
        load_en     = 1'b0;
        load_dmem   = 1'b0;
        load_addr   = '0;
        load_data   = '0;
        dbg_reg_sel = '0;

        for (int i = 0; i < DEPTH; i++) prog[i] = 32'h0;
        for (int i = 0; i < 32; i++) begin
            ref_r[i]     = 32'h0;
            ref_known[i] = 1'b0;
        end
        prog[0]  = enc_i(6'h0D, 0, 1, 16'h8005);
        prog[1]  = enc_i(6'h0D, 0, 2, 16'h0003);
        prog[2]  = enc_r(1, 2, 3, 6'h21);
        prog[3]  = enc_r(2, 1, 4, 6'h23);
        prog[4]  = enc_i(6'h2B, 0, 3, 16'h0008);
        prog[5]  = enc_i(6'h23, 0, 5, 16'h0008);
        prog[6]  = enc_i(6'h2B, 0, 4, 16'hFFFC);
        prog[7]  = enc_i(6'h23, 0, 6, 16'h00FC);
        prog[8]  = enc_i(6'h23, 0, 7, 16'h000A);
        prog[9]  = enc_i(6'h23, 0, 10, 16'h0028);
        prog[10] = enc_r(1, 2, 0, 6'h21);
        prog[11] = enc_i(6'h04, 1, 2, 16'h0005);
        prog[12] = enc_r(1, 2, 3, 6'h20);
        prog[13] = enc_i(6'h3F, 0, 4, 16'h1234);
        prog[14] = enc_i(6'h04, 5, 3, 16'h0002);
        prog[15] = enc_i(6'h0D, 0, 6, 16'hDEAD);
        prog[16] = enc_i(6'h0D, 0, 6, 16'hBEEF);
        prog[17] = enc_i(6'h04, 0, 0, 16'hFFFF);

        // R11: place program and data through the load port while in reset
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_dmem = 1'b0;
            load_addr = AW'(i);
            load_data = prog[i];
        end
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            load_en   = 1'b1;
            load_dmem = 1'b1;
            load_addr = AW'(i);
            load_data = (i == 10) ? 32'h1234_5678 : 32'h0;
            ref_m[i]  = load_data;
        end
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
        check("R1 PC held at zero in reset", dbg_pc, 32'h0);

        rst    = 1'b0;
        ref_pc = 32'h0;
        for (int c = 0; c < 24; c++) begin
            @(posedge clk);
            ref_step();
            @(negedge clk);
            check("R12 R7 R6 PC after each instruction", dbg_pc, ref_pc);
        end
        // forward branch from word 14 lands on word 17, which branches to itself
        check("R6 taken branch target then self-loop", dbg_pc, 32'd68);

        for (int r = 0; r < 32; r++) begin
            if (r == 0 || ref_known[r]) begin
                dbg_reg_sel = 5'(r);
                #1;
                check(reg_tag(r), dbg_reg_data, ref_r[r]);
            end
        end

        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R1 PC returns to zero on reset mid-run", dbg_pc, 32'h0);
        dbg_reg_sel = 5'd1;
        #1;
        check("R1 R3 register kept across reset", dbg_reg_data, 32'h0000_8005);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule